// File: doc/BRIEF.md
# ADC Result Window Comparator

This block sits beside an analog-to-digital converter and inspects every result the converter reports with its result-valid strobe. It holds two 16-bit limits, an upper bound ("above" limit) and a lower bound ("below" limit). When a result meets the window condition it sets a single sticky flag. Software may wire that flag to an interrupt or poll it, and clears it with a one-cycle clear pulse.

The direction of detection comes only from the two limits, with no mode bit. When the below limit exceeds the above limit, the flag marks results that fall between them. Otherwise the flag marks results that fall beyond them. Software writes each limit one byte at a time. The high byte is held aside until the matching low byte arrives, so a comparison never sees a half-written limit.

Top module: `adc_window_flag`

## Requirements
- R1: After reset `win_flag` is 0, the above limit is 0xFFFF and the below limit is 0x0000, so no result sets the flag until software loads new limits.
- R2: When below limit > above limit, a valid result sets the flag if and only if it is strictly greater than the above limit and strictly less than the below limit.
- R3: When below limit <= above limit (equal limits included), a valid result sets the flag if and only if it is strictly greater than the above limit or strictly less than the below limit.
- R4: Writes use `wr_sel`: 0 = above limit low byte, 1 = above limit high byte, 2 = below limit low byte, 3 = below limit high byte. A high-byte write changes no comparison. The low-byte write loads the full 16-bit limit from the latest high byte and the new low byte.
- R5: Once set, the flag stays at 1 until `flag_clr` is pulsed. A clear with no hit in the same cycle returns the flag to 0.
- R6: If a hit and `flag_clr` occur in the same cycle, the flag is 1 afterwards.
- R7: While `res_valid` is low, `res_data` has no effect on the flag.
- R8: A hit presented at a clock edge shows on `win_flag` right after that edge, with no extra cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Limit byte write strobe |
| wr_sel | input | 2 | Selects which limit byte is written (see R4) |
| wr_data | input | 8 | Byte written |
| res_valid | input | 1 | New ADC result is present |
| res_data | input | 16 | ADC result |
| flag_clr | input | 1 | Clears the window flag |
| win_flag | output | 1 | Sticky window flag |

## Verification
Each of several limit pairs is loaded, and results are swept over a coarse grid plus each limit, its neighbours and both ends of the range. Inside pairs, outside pairs, equal limits and the reset limits together separate the two detection directions and catch an off-by-one in strict versus inclusive comparison. A split high-byte write is tested with a result whose outcome differs between the old limit and an early-committed one. Separate tests cover sticky holding, the clear racing a hit, and a matching result presented with the strobe low.

// File: rtl/adc_window_flag.sv
module adc_window_flag #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [7:0]   wr_data,
  input  logic         res_valid,
  input  logic [W-1:0] res_data,
  input  logic         flag_clr,
  output logic         win_flag
);
  localparam int HW = W - 8;

  logic [W-1:0]  above_q, below_q;
  logic [HW-1:0] above_hi_stage, below_hi_stage;
  logic          inside_mode, hit;

  assign inside_mode = below_q > above_q;
  assign hit = inside_mode ? (res_data > above_q) && (res_data < below_q)
                           : (res_data > above_q) || (res_data < below_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      above_q        <= '1;
      below_q        <= '0;
      above_hi_stage <= '1;
      below_hi_stage <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: above_q        <= {above_hi_stage, wr_data};
        2'd1: above_hi_stage <= wr_data[HW-1:0];
        2'd2: below_q        <= {below_hi_stage, wr_data};
        2'd3: below_hi_stage <= wr_data[HW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                win_flag <= 1'b0;
    else if (res_valid && hit) win_flag <= 1'b1;
    else if (flag_clr)         win_flag <= 1'b0;
  end

  AST_HIGH_BYTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel[0]) |=> ($stable(above_q) && $stable(below_q))); // R4
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (win_flag && !flag_clr) |=> win_flag); // R5
  AST_NO_STROBE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && !win_flag) |=> !win_flag); // R7
  AST_INSIDE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && below_q > above_q && res_data > above_q && res_data < below_q) |=> win_flag); // R2
  AST_OUTSIDE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && below_q <= above_q && (res_data > above_q || res_data < below_q)) |=> win_flag); // R3
  AST_CLEAR_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !res_valid) |=> !win_flag); // R5
endmodule

// File: tb/test_adc_window_flag.sv
module test_adc_window_flag;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic        res_valid = 1'b0;
  logic [15:0] res_data = '0;
  logic        flag_clr = 1'b0;
  logic        win_flag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adc_window_flag i_adc_window_flag (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .res_valid(res_valid), .res_data(res_data), .flag_clr(flag_clr), .win_flag(win_flag)
  );

  function automatic bit expect_hit(input logic [15:0] v, input logic [15:0] ab, input logic [15:0] be);
    if (be > ab) return (v > ab) && (v < be);
    return (v > ab) || (v < be);
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: win_flag=%0b expected=%0b", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input logic [15:0] ab, input logic [15:0] be);
    wr(2'd1, ab[15:8]); wr(2'd0, ab[7:0]);
    wr(2'd3, be[15:8]); wr(2'd2, be[7:0]);
  endtask

  task automatic present(input logic [15:0] v, input logic clr);
    res_valid = 1'b1; res_data = v; flag_clr = clr;
    @(negedge clk);
    res_valid = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic clear();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic sweep(input string req, input logic [15:0] ab, input logic [15:0] be);
    logic [15:0] pts [26];
    pts[0] = 16'h0000; pts[1] = 16'h0001; pts[2] = 16'hFFFE; pts[3] = 16'hFFFF;
    pts[4] = ab - 16'd1; pts[5] = ab; pts[6] = ab + 16'd1;
    pts[7] = be - 16'd1; pts[8] = be; pts[9] = be + 16'd1;
    for (int k = 0; k < 16; k++) pts[10+k] = 16'(k * 4369);
    for (int i = 0; i < 26; i++) begin
      present(pts[i], 1'b0);
      check(req, win_flag, expect_hit(pts[i], ab, be));
      clear();
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset", win_flag, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R1 reset limits", 16'hFFFF, 16'h0000);

    load(16'h1000, 16'h2000); sweep("R2 inside", 16'h1000, 16'h2000);
    load(16'h0000, 16'hFFFF); sweep("R2 inside full", 16'h0000, 16'hFFFF);
    load(16'h7FFF, 16'h8001); sweep("R2 inside narrow", 16'h7FFF, 16'h8001);
    load(16'h2000, 16'h1000); sweep("R3 outside", 16'h2000, 16'h1000);
    load(16'h8000, 16'h8000); sweep("R3 equal limits", 16'h8000, 16'h8000);

    // R8: flag visible right after the strobe edge
    load(16'h1000, 16'h2000);
    present(16'h1800, 1'b0);
    check("R8 latency", win_flag, 1'b1);
    clear();

    // R4: high byte alone must not change the limit
    wr(2'd1, 8'h30);
    present(16'h0800, 1'b0);
    check("R4 high byte staged", win_flag, 1'b0);
    wr(2'd0, 8'h00);
    present(16'h0800, 1'b0);
    check("R4 low byte commits", win_flag, 1'b1);
    clear();
    check("R5 clear", win_flag, 1'b0);

    // R5: sticky across misses
    load(16'h1000, 16'h2000);
    present(16'h1800, 1'b0);
    for (int i = 0; i < 4; i++) begin
      present(16'h3000, 1'b0);
      check("R5 sticky", win_flag, 1'b1);
    end
    @(negedge clk);
    check("R5 sticky idle", win_flag, 1'b1);

    // R6: hit with clear in the same cycle
    present(16'h1800, 1'b1);
    check("R6 set wins", win_flag, 1'b1);
    present(16'h3000, 1'b1);
    check("R5 clear with miss", win_flag, 1'b0);

    // R7: matching data without the strobe
    res_data = 16'h1800;
    repeat (3) @(negedge clk);
    check("R7 no strobe", win_flag, 1'b0);
    flag_clr = 1'b1; res_data = 16'h1900;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R7 no strobe with clear", win_flag, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule